// File: doc/BRIEF.md
# Counting-Ramp ADC Sequencer

This block sequences a staircase-ramp analog-to-digital conversion. It drives the code of an external DAC from a binary counter and reads back a single comparator bit that stays high while the DAC level is still below the analog input. After a start pulse, the counter is cleared and then advances one code per step. When the comparator drops, stepping stops and the final code is captured as the result.

Counting is gated by a run latch. A start pulse sets the latch. A comparator trip, or reaching full scale, clears it. While the latch is clear, the DAC code does not move, even if the comparator reads high.

The comparator bit is asynchronous to the block, so it passes through a flop synchronizer. Each step lasts long enough for the comparator's answer to the current code to arrive through that synchronizer before the block decides whether to step again. Because of this, the counter never overshoots. A step lasts `SYNC_STAGES + 1 + SETTLE_CYCLES` clocks, and a full-scale conversion takes 2^N steps.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `dac_code_o`, `result_o` and `done_o` are all zero.
- R2: While no conversion is running, `dac_code_o` holds its value whatever the comparator input reads, until a start pulse is accepted.
- R3: A start pulse seen at a clock edge while idle sets the run latch and clears `dac_code_o` to zero at that same edge.
- R4: While running, `dac_code_o` changes only by +1, and only at decision edges spaced STEP = SYNC_STAGES + 1 + SETTLE_CYCLES clocks apart. The first decision edge comes STEP clocks after the start edge.
- R5: At a decision edge, a synchronized comparator value of 0 (meaning the DAC is not below the input) stops the run with no further count. `result_o` takes the current code. With an ideal comparator (`cmp_below_i` = code < vin), the result is vin for vin ≤ 2^N − 1.
- R6: If the comparator still reads 1 at a decision edge while the code is all ones, the run stops with `result_o` all ones, and `done_o` still pulses.
- R7: `done_o` is high for exactly one cycle. That cycle follows the edge that comes (result + 1) × STEP clocks after the start edge.
- R8: `result_o` changes only together with a `done_o` pulse and holds its value between conversions.
- R9: A start pulse that arrives during a conversion is ignored: the code is not cleared, and the completion time and the result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a conversion (one-cycle pulse) |
| cmp_below_i | input | 1 | Asynchronous comparator: 1 while the DAC output is below the input |
| dac_code_o | output | N | Code driving the external DAC |
| result_o | output | N | Last conversion result |
| done_o | output | 1 | One-cycle pulse when `result_o` is updated |

## Verification
A wrong step timer or a synchronizer of the wrong depth shows up at the ports as a staircase whose steps change at the wrong clock. It also shifts the done pulse by a fixed number of cycles for every input value. The bench therefore checks the staircase at every clock of every conversion, from the first step onward. A stop decision that reads a stale comparator overshoots, so the result comes out one or more codes too high. A run latch that fails to hold or to release appears as a code that moves while idle, or as a conversion that restarts when a second start pulse arrives. Both are visible within one step of the fault. The input sweep covers every in-range input value and several values beyond full scale, so the zero-input case and saturation are both exercised.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

    // Outcome of one step window
    typedef enum logic [1:0] {
        DEC_WAIT = 2'd0,   // window still open, comparator not yet valid
        DEC_STEP = 2'd1,   // still below input: advance one code
        DEC_HIT  = 2'd2,   // input reached: stop
        DEC_FULL = 2'd3    // all ones and still below: saturate and stop
    } ramp_dec_e;

    function automatic int unsigned step_len(int unsigned sync_stages,
                                             int unsigned settle_cycles);
        return sync_stages + 1 + settle_cycles;
    endfunction

endpackage

// File: rtl/ramp_cmp_sync.sv
module ramp_cmp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ramp_step_timer.sv
module ramp_step_timer #(
    parameter int unsigned STEP_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic enable_i,
    output logic tick_o
);
    localparam int unsigned TW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(STEP_CYCLES - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    assign tick_o = enable_i && !clear_i && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i || !enable_i) cnt_d = '0;
        else if (tick_o)          cnt_d = '0;
        else                      cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: the window counter never passes its last value
    timer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/ramp_decide.sv
module ramp_decide
    import ramp_adc_pkg::*;
#(
    parameter int unsigned N = 10
) (
    input  logic         tick_i,
    input  logic         below_i,
    input  logic [N-1:0] code_i,
    output ramp_dec_e    dec_o
);
    always_comb begin
        if (!tick_i)            dec_o = DEC_WAIT;
        else if (!below_i)      dec_o = DEC_HIT;
        else if (&code_i)       dec_o = DEC_FULL;
        else                    dec_o = DEC_STEP;
    end
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
    import ramp_adc_pkg::*;
#(
    parameter int unsigned N             = 10,
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned SETTLE_CYCLES = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         cmp_below_i,
    output logic [N-1:0] dac_code_o,
    output logic [N-1:0] result_o,
    output logic         done_o
);
    localparam int unsigned STEP = step_len(SYNC_STAGES, SETTLE_CYCLES);

    typedef struct packed {
        logic         run;
        logic [N-1:0] code;
        logic [N-1:0] result;
        logic         done;
    } seq_t;

    seq_t      s_d, s_q;
    logic      below_sync;
    logic      tick;
    logic      accept;
    ramp_dec_e dec;

    assign accept = start_i && !s_q.run;

    ramp_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cmp_below_i),
        .sync_o  (below_sync)
    );

    ramp_step_timer #(.STEP_CYCLES(STEP)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .enable_i (s_q.run),
        .tick_o   (tick)
    );

    ramp_decide #(.N(N)) u_decide (
        .tick_i  (tick),
        .below_i (below_sync),
        .code_i  (s_q.code),
        .dec_o   (dec)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.run) begin
            if (start_i) begin
                s_d.run  = 1'b1;
                s_d.code = '0;
            end
        end else begin
            unique case (dec)
                DEC_STEP: s_d.code = s_q.code + 1'b1;
                DEC_HIT, DEC_FULL: begin
                    s_d.run    = 1'b0;
                    s_d.done   = 1'b1;
                    s_d.result = s_q.code;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dac_code_o = s_q.code;
    assign result_o   = s_q.result;
    assign done_o     = s_q.done;

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.run && !start_i) |=> $stable(dac_code_o));

    // R3
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !s_q.run) |=> (dac_code_o == '0) && s_q.run);

    // R4
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && $past(s_q.run) && !$stable(dac_code_o))
            |-> (dac_code_o == N'($past(dac_code_o) + 1'b1)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (done_o || $stable(result_o)));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && s_q.run && dec == DEC_WAIT) |=> $stable(dac_code_o));
endmodule

// File: tb/ramp_adc_ctrl_tb.sv
module ramp_adc_ctrl_tb_top;
    localparam int N      = 6;
    localparam int SYNC   = 2;
    localparam int SETTLE = 1;
    localparam int STEP   = SYNC + 1 + SETTLE;
    localparam int MAXC   = (1 << N) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         cmp_below_i;
    logic [N-1:0] dac_code_o, result_o;
    logic         done_o;
    int           vin = 0;
    int           total = 0;
    int           bad = 0;
    int           cyc = 0;

    always #4 clk = ~clk;   // 125 MHz

    // ideal analog model: DAC plus comparator
    assign cmp_below_i = (int'(dac_code_o) < vin);

    ramp_adc_ctrl #(.N(N), .SYNC_STAGES(SYNC), .SETTLE_CYCLES(SETTLE)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cmp_below_i (cmp_below_i),
        .dac_code_o  (dac_code_o),
        .result_o    (result_o),
        .done_o      (done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            $display("FAIL R7 watchdog actual=%0d expected=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // One conversion; inject>0 pulses start again that many clocks in
    task automatic convert(input int v, input int inject);
        int exp_r, k, stair_err, prev_res;
        bit seen;
        exp_r = (v > MAXC) ? MAXC : v;
        prev_res = int'(result_o);
        vin = v;
        @(negedge clk); start_i = 1'b1;
        @(posedge clk);
        @(negedge clk); start_i = 1'b0;
        chk(dac_code_o == '0, "R3 code cleared at start", int'(dac_code_o), 0);
        chk(int'(result_o) == prev_res, "R8 result held during run", int'(result_o), prev_res);
        k = 0; stair_err = 0; seen = 1'b0;
        while (!seen && k < (MAXC + 3) * STEP) begin
            if (inject > 0 && k == inject) start_i = 1'b1;
            @(posedge clk); k++;
            @(negedge clk);
            start_i = 1'b0;
            if (done_o) seen = 1'b1;
            else if (int'(dac_code_o) != k / STEP) stair_err++;
        end
        chk(stair_err == 0, (inject > 0) ? "R9 busy start ignored (staircase)" : "R4 staircase timing",
            stair_err, 0);
        chk(k == (exp_r + 1) * STEP, (inject > 0) ? "R9 completion time" : "R7 done timing",
            k, (exp_r + 1) * STEP);
        chk(int'(result_o) == exp_r, (v > MAXC) ? "R6 saturated result" : "R5 result", int'(result_o), exp_r);
        @(negedge clk);
        chk(!done_o, "R7 done single cycle", int'(done_o), 0);
        repeat (3) @(negedge clk);
        chk(int'(result_o) == exp_r, "R8 result held idle", int'(result_o), exp_r);
        chk(int'(dac_code_o) == exp_r, "R2 code frozen idle", int'(dac_code_o), exp_r);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(dac_code_o == '0 && result_o == '0 && !done_o, "R1 reset state",
            int'(dac_code_o) + int'(result_o) + int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dac_code_o == '0 && result_o == '0 && !done_o, "R1 after release",
            int'(dac_code_o) + int'(result_o) + int'(done_o), 0);
        // R2: comparator high while idle must not start counting
        vin = 20;
        repeat (12) @(negedge clk);
        chk(dac_code_o == '0, "R2 idle no count", int'(dac_code_o), 0);
        // full sweep including inputs beyond full scale
        for (int v = 0; v <= MAXC + 6; v++) convert(v, 0);
        // R9: start pulses inside running conversions
        convert(40, 50);
        convert(MAXC + 3, 7);
        convert(0, 1);
        convert(5, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule